// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This controller schedules decoded floating-point instructions onto a small set of functional units. It takes one instruction at a time, in program order. Each instruction carries an operation class, a destination register and two source registers. The controller keeps a record for every unit and a per-register table of pending writers. From these it decides three things: when an instruction may be issued to a unit, when a unit may read its source operands, and when a finished unit may write its result back. The units do the arithmetic themselves. They report completion with a one-cycle done pulse, and they act on the grants the controller gives them.

Issue stalls only on structural and write-after-write conflicts. Read-after-write dependencies are resolved per unit at operand-read time, with no forwarding. Write-after-read conflicts are resolved at write-back. As a result, later independent instructions may read, execute and retire ahead of earlier stalled ones. The default configuration has five units: one integer/load unit, two multipliers, one adder and one divider. It tracks 32 registers.

Top module: `sb_ctrl`

## Requirements
- R1: After reset all units are idle, no register has a pending writer, and `rd_grant`, `wr_grant` and `issue_unit` are all zero until an instruction is issued.
- R2: Classes map to units as follows: class 0 is unit 0 (integer/load), class 1 is units 1 and 2 (multiply), class 2 is unit 3 (add) and class 3 is unit 4 (divide). An offered instruction is accepted only if a unit of its class is idle. It goes to the idle unit of that class with the lowest index, and `issue_unit` shows that unit as one-hot in the same cycle.
- R3: An offered instruction is not accepted while any active unit has the same destination register. The same instruction must then stay offered until it is accepted.
- R4: A unit whose two sources have no pending writer at issue becomes eligible for its read grant in the cycle after it is issued, and never in the issue cycle.
- R5: A unit whose source has a pending writer gets no read grant until that writer has received its write grant. It becomes eligible in the following cycle. A writer that retires in the same cycle as an issue counts as no pending writer for that issue.
- R6: At most one read grant and at most one write grant are given per cycle. Among eligible units the lowest index wins, and the others wait.
- R7: A done pulse is taken only from a unit that received its read grant in an earlier cycle. That unit is then eligible for its write grant from the next cycle on.
- R8: A completed unit is refused its write grant while another active unit has the completed unit's destination as a source that it has not yet read.
- R9: A unit that receives its write grant is idle in the next cycle, and its destination no longer blocks issue.
- R10: Done pulses to an idle unit, to a unit that has not yet read, or to a unit that has already completed are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is offered |
| in_class | input | 2 | Operation class of the offered instruction |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| fu_done | input | 5 | Per-unit execution complete pulse |
| issue_accept | output | 1 | Offered instruction is issued this cycle |
| issue_unit | output | 5 | One-hot unit that receives the instruction |
| rd_grant | output | 5 | One-hot permission to read operands |
| wr_grant | output | 5 | One-hot permission to write the result |

## Verification
Directed sequences cover several cases. A divide-then-dependent-add chain, with an independent multiply, separates in-order read from out-of-order read (RAW tracking). A destination reuse separates a WAW stall from an accidental issue. A late multiply whose destination is still an unread source of a waiting add separates correct WAR blocking from an early write-back. Two consumers of one producer become ready in the same cycle, which tests the fixed-priority read arbitration. Stray done pulses show whether completion is taken only after a read. A long run of seeded random instructions follows. It uses few registers, so dependencies are dense, and sparse random done pulses. Every cycle is compared against an independent scoreboard model in the bench.

// File: rtl/sb_pkg.sv
package sb_pkg;
    parameter int NUM_FU  = 5;
    parameter int NUM_REG = 32;
    parameter int CLS_W   = 2;
    localparam int RIDX_W = $clog2(NUM_REG);
    localparam int TAG_W  = $clog2(NUM_FU + 1);

    typedef logic [RIDX_W-1:0] reg_t;
    typedef logic [TAG_W-1:0]  tag_t;   // 0 = no pending writer, else unit index + 1
    typedef logic [CLS_W-1:0]  cls_t;

    typedef struct packed {
        logic busy;
        logic rd_done;
        logic cmp;
        cls_t op;
        reg_t fi;
        reg_t fj;
        reg_t fk;
        tag_t qj;
        tag_t qk;
        logic rj;
        logic rk;
    } fu_t;

    // unit 0: int/load, last: divide, next to last: add, rest: multiply
    function automatic cls_t unit_class(input int idx);
        if (idx == 0)               return cls_t'(0);
        else if (idx == NUM_FU - 1) return cls_t'(3);
        else if (idx == NUM_FU - 2) return cls_t'(2);
        else                        return cls_t'(1);
    endfunction
endpackage

// File: rtl/sb_pick.sv
module sb_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard
    import sb_pkg::*;
(
    input  fu_t [NUM_FU-1:0]  fu,
    output logic [NUM_FU-1:0] rd_elig,
    output logic [NUM_FU-1:0] wr_elig
);
    for (genvar u = 0; u < NUM_FU; u++) begin : g_unit
        logic war;
        always_comb begin
            war = 1'b0;
            for (int v = 0; v < NUM_FU; v++) begin
                if (v != u && fu[v].busy &&
                    ((fu[v].fj == fu[u].fi && fu[v].rj) ||
                     (fu[v].fk == fu[u].fi && fu[v].rk)))
                    war = 1'b1;
            end
        end
        assign rd_elig[u] = fu[u].busy && !fu[u].rd_done && fu[u].rj && fu[u].rk;
        assign wr_elig[u] = fu[u].busy && fu[u].cmp && !war;
    end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CLS_W-1:0]  in_class,
    input  logic [RIDX_W-1:0] in_dst,
    input  logic [RIDX_W-1:0] in_src1,
    input  logic [RIDX_W-1:0] in_src2,
    input  logic [NUM_FU-1:0] fu_done,
    output logic              issue_accept,
    output logic [NUM_FU-1:0] issue_unit,
    output logic [NUM_FU-1:0] rd_grant,
    output logic [NUM_FU-1:0] wr_grant
);
    typedef struct packed {
        fu_t  [NUM_FU-1:0]  fu;
        tag_t [NUM_REG-1:0] rstat;
    } sb_state_t;

    sb_state_t st_d, st_q;

    logic [NUM_FU-1:0] free_match_d;
    logic [NUM_FU-1:0] rd_elig_d, wr_elig_d;
    logic              waw_d;
    tag_t              wr_tag_d;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_free
        assign free_match_d[u] = !st_q.fu[u].busy && (unit_class(u) == in_class);
    end

    assign waw_d = (st_q.rstat[in_dst] != '0);

    sb_pick #(.N(NUM_FU)) u_issue_pick (
        .req (free_match_d & {NUM_FU{in_valid && !waw_d}}),
        .gnt (issue_unit)
    );
    assign issue_accept = |issue_unit;

    sb_hazard u_hazard (
        .fu      (st_q.fu),
        .rd_elig (rd_elig_d),
        .wr_elig (wr_elig_d)
    );

    sb_pick #(.N(NUM_FU)) u_rd_pick (.req(rd_elig_d), .gnt(rd_grant));
    sb_pick #(.N(NUM_FU)) u_wr_pick (.req(wr_elig_d), .gnt(wr_grant));

    always_comb begin
        wr_tag_d = '0;
        for (int w = 0; w < NUM_FU; w++)
            if (wr_grant[w]) wr_tag_d = TAG_W'(w + 1);
    end

    always_comb begin
        st_d = st_q;
        // completion pulses, only after a read in an earlier cycle
        for (int u = 0; u < NUM_FU; u++) begin
            if (fu_done[u] && st_q.fu[u].busy && st_q.fu[u].rd_done && !wr_grant[u])
                st_d.fu[u].cmp = 1'b1;
        end
        // write-back: free unit, clear pending writer, release waiting readers
        for (int w = 0; w < NUM_FU; w++) begin
            if (wr_grant[w]) begin
                st_d.fu[w].busy    = 1'b0;
                st_d.fu[w].rd_done = 1'b0;
                st_d.fu[w].cmp     = 1'b0;
                st_d.rstat[st_q.fu[w].fi] = '0;
                for (int v = 0; v < NUM_FU; v++) begin
                    if (st_q.fu[v].qj == TAG_W'(w + 1)) begin
                        st_d.fu[v].qj = '0;
                        st_d.fu[v].rj = 1'b1;
                    end
                    if (st_q.fu[v].qk == TAG_W'(w + 1)) begin
                        st_d.fu[v].qk = '0;
                        st_d.fu[v].rk = 1'b1;
                    end
                end
            end
        end
        // operand read: clear ready flags so WAR sees only unread sources
        for (int u = 0; u < NUM_FU; u++) begin
            if (rd_grant[u]) begin
                st_d.fu[u].rd_done = 1'b1;
                st_d.fu[u].rj      = 1'b0;
                st_d.fu[u].rk      = 1'b0;
            end
        end
        // issue
        for (int u = 0; u < NUM_FU; u++) begin
            if (issue_unit[u]) begin
                st_d.fu[u].busy    = 1'b1;
                st_d.fu[u].rd_done = 1'b0;
                st_d.fu[u].cmp     = 1'b0;
                st_d.fu[u].op      = in_class;
                st_d.fu[u].fi      = in_dst;
                st_d.fu[u].fj      = in_src1;
                st_d.fu[u].fk      = in_src2;
                st_d.fu[u].qj      = (st_q.rstat[in_src1] == wr_tag_d) ? '0 : st_q.rstat[in_src1];
                st_d.fu[u].qk      = (st_q.rstat[in_src2] == wr_tag_d) ? '0 : st_q.rstat[in_src2];
                st_d.fu[u].rj      = (st_q.rstat[in_src1] == '0) || (st_q.rstat[in_src1] == wr_tag_d);
                st_d.fu[u].rk      = (st_q.rstat[in_src2] == '0) || (st_q.rstat[in_src2] == wr_tag_d);
                st_d.rstat[in_dst] = TAG_W'(u + 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sb_ctrl_chk.sv
module sb_ctrl_chk
    import sb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_FU-1:0] fu_done,
    input logic              issue_accept,
    input logic [NUM_FU-1:0] issue_unit,
    input logic [NUM_FU-1:0] rd_grant,
    input logic [NUM_FU-1:0] wr_grant
);
    logic [NUM_FU-1:0] rd_seen_q, dn_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_seen_q <= '0;
            dn_seen_q <= '0;
        end else begin
            rd_seen_q <= (rd_seen_q | rd_grant) & ~wr_grant;
            dn_seen_q <= (dn_seen_q | (fu_done & rd_seen_q)) & ~wr_grant;
        end
    end

    AST_RD_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rd_grant)); // R6
    AST_WR_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_grant)); // R6
    AST_ISSUE_ONE_UNIT: assert property (@(posedge clk) disable iff (!rst_n) issue_accept |-> ($countones(issue_unit) == 1)); // R2
    AST_NO_READ_AT_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) (issue_unit & rd_grant) == '0); // R4
    AST_WR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) (wr_grant & ~rd_seen_q) == '0); // R7
    AST_WR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) (wr_grant & ~dn_seen_q) == '0); // R7
    AST_FREE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) |wr_grant |=> ((rd_grant & $past(wr_grant)) == '0)); // R9
endmodule

bind sb_ctrl sb_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fu_done      (fu_done),
    .issue_accept (issue_accept),
    .issue_unit   (issue_unit),
    .rd_grant     (rd_grant),
    .wr_grant     (wr_grant)
);

// File: tb/sim_sb_ctrl.sv
module sim_sb_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_class = '0;
    logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [4:0] fu_done = '0;
    logic       issue_accept;
    logic [4:0] issue_unit, rd_grant, wr_grant;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    sb_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .fu_done(fu_done),
        .issue_accept(issue_accept), .issue_unit(issue_unit),
        .rd_grant(rd_grant), .wr_grant(wr_grant)
    );

    // independent scoreboard model
    int mb[5], mrd[5], mcmp[5], mfi[5], mfj[5], mfk[5], mqj[5], mqk[5], mrj[5], mrk[5];
    int mrs[32];
    logic last_acc;

    function automatic int cls_of(int u);
        if (u == 0) return 0;
        if (u == 4) return 3;
        if (u == 3) return 2;
        return 1;
    endfunction

    function automatic logic [4:0] oh(int idx);
        return (idx < 0) ? 5'b0 : (5'b1 << idx);
    endfunction

    task automatic mreset();
        for (int u = 0; u < 5; u++) begin
            mb[u] = 0; mrd[u] = 0; mcmp[u] = 0; mfi[u] = 0; mfj[u] = 0; mfk[u] = 0;
            mqj[u] = -1; mqk[u] = -1; mrj[u] = 0; mrk[u] = 0;
        end
        for (int r = 0; r < 32; r++) mrs[r] = -1;
    endtask

    task automatic chk(string tag, string name, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, name, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; fu_done = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mreset();
    endtask

    task automatic step(logic v, int c, int d, int s1, int s2, logic [4:0] dn, string tag);
        int eu, er, ew;
        @(negedge clk);
        in_valid = v; in_class = c[1:0]; in_dst = d[4:0];
        in_src1 = s1[4:0]; in_src2 = s2[4:0]; fu_done = dn;
        #1;
        eu = -1; er = -1; ew = -1;
        if (v && mrs[d] < 0)
            for (int u = 0; u < 5; u++)
                if (eu < 0 && mb[u] == 0 && cls_of(u) == c) eu = u;
        for (int u = 0; u < 5; u++)
            if (er < 0 && mb[u] != 0 && mrd[u] == 0 && mrj[u] != 0 && mrk[u] != 0) er = u;
        for (int u = 0; u < 5; u++) begin
            if (ew < 0 && mb[u] != 0 && mcmp[u] != 0) begin
                bit war = 0;
                for (int x = 0; x < 5; x++)
                    if (x != u && mb[x] != 0 &&
                        ((mfj[x] == mfi[u] && mrj[x] != 0) || (mfk[x] == mfi[u] && mrk[x] != 0)))
                        war = 1;
                if (!war) ew = u;
            end
        end
        chk(tag, "issue_accept", {4'b0, issue_accept}, {4'b0, eu >= 0});
        chk(tag, "issue_unit", issue_unit, oh(eu));
        chk(tag, "rd_grant", rd_grant, oh(er));
        chk(tag, "wr_grant", wr_grant, oh(ew));
        last_acc = (eu >= 0);
        for (int u = 0; u < 5; u++)
            if (dn[u] && mb[u] != 0 && mrd[u] != 0 && u != ew) mcmp[u] = 1;
        if (ew >= 0) begin
            mb[ew] = 0; mrd[ew] = 0; mcmp[ew] = 0; mrs[mfi[ew]] = -1;
            for (int x = 0; x < 5; x++) begin
                if (mqj[x] == ew) begin mqj[x] = -1; mrj[x] = 1; end
                if (mqk[x] == ew) begin mqk[x] = -1; mrk[x] = 1; end
            end
        end
        if (er >= 0) begin mrd[er] = 1; mrj[er] = 0; mrk[er] = 0; end
        if (eu >= 0) begin
            mb[eu] = 1; mrd[eu] = 0; mcmp[eu] = 0;
            mfi[eu] = d; mfj[eu] = s1; mfk[eu] = s2;
            mqj[eu] = mrs[s1]; mqk[eu] = mrs[s2];
            mrj[eu] = (mrs[s1] < 0); mrk[eu] = (mrs[s2] < 0);
            mrs[d] = eu;
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pc, pd, p1, p2;
        logic pv;
        mreset();
        do_reset();
        // R1: idle after reset
        step(0, 0, 0, 0, 0, 5'b0, "R1");
        chk("R1", "rd_grant idle", rd_grant, 5'b0);
        // divide F0 <- F2,F4
        step(1, 3, 0, 2, 4, 5'b0, "R2");
        // add F10 <- F0,F8 ; divide reads now
        step(1, 2, 10, 0, 8, 5'b0, "R4");
        chk("R4", "rd_grant after issue", rd_grant, 5'b10000);
        // multiply F6 <- F6,F14 ; add waits on F0
        step(1, 1, 6, 6, 14, 5'b0, "R5");
        // second multiply; divide completes; done to idle unit 0 ignored
        step(1, 1, 12, 1, 1, 5'b10001, "R10");
        // WAW: divide F10 while add owns F10 -> stalls; divide writes back
        step(1, 3, 10, 3, 3, 5'b0, "R3");
        step(1, 3, 10, 3, 3, 5'b0, "R3");
        // divide unit free again after write-back
        step(1, 3, 0, 2, 4, 5'b10000, "R9");
        step(0, 0, 0, 0, 0, 5'b0, "R7");
        step(0, 0, 0, 0, 0, 5'b01110, "R7");
        repeat (6) step(0, 0, 0, 0, 0, 5'b11110, "R7");

        // R6: two consumers released by one producer in the same cycle
        do_reset();
        step(1, 3, 1, 2, 3, 5'b0, "R6");
        step(1, 2, 5, 1, 2, 5'b0, "R6");
        step(1, 1, 7, 1, 3, 5'b10000, "R6");
        repeat (4) step(0, 0, 0, 0, 0, 5'b0, "R6");
        repeat (4) step(0, 0, 0, 0, 0, 5'b01010, "R6");

        // R8: multiply writes F2 while add still has F2 unread
        do_reset();
        step(1, 3, 1, 9, 9, 5'b0, "R8");
        step(1, 2, 3, 1, 2, 5'b0, "R8");
        step(1, 1, 2, 4, 5, 5'b0, "R8");
        step(0, 0, 0, 0, 0, 5'b0, "R8");
        step(0, 0, 0, 0, 0, 5'b00010, "R8");
        repeat (3) step(0, 0, 0, 0, 0, 5'b0, "R8");
        chk("R8", "wr_grant blocked", wr_grant, 5'b0);
        step(0, 0, 0, 0, 0, 5'b10000, "R8");
        repeat (4) step(0, 0, 0, 0, 0, 5'b0, "R8");
        repeat (4) step(0, 0, 0, 0, 0, 5'b01000, "R8");

        // constrained random with dense register reuse
        do_reset();
        void'($urandom(32'd4711));
        pv = 1'b1; pc = $urandom % 4; pd = $urandom % 8; p1 = $urandom % 8; p2 = $urandom % 8;
        for (int n = 0; n < 4000; n++) begin
            logic [4:0] dn;
            for (int b = 0; b < 5; b++) dn[b] = ($urandom % 4) == 0;
            step(pv, pc, pd, p1, p2, dn, (n % 2) ? "R3" : "R5");
            if (last_acc || !pv) begin
                pv = ($urandom % 4) != 0;
                pc = $urandom % 4; pd = $urandom % 8; p1 = $urandom % 8; p2 = $urandom % 8;
            end
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule